// File: doc/BRIEF.md
# Three-Bit-Coded Integer ALU

This block is a purely combinational integer arithmetic-logic unit of parameterised width, 32 bits by default. It takes two operands and a three-bit function code and returns one result word and an adder carry-out. It is meant to sit in the execute stage of a simple processor datapath, where the decoder supplies the function code.

All arithmetic goes through one adder. The top function bit inverts the second operand before it reaches either the logic gates or the adder, and it also serves as the adder carry-in. With this bit set, the adder forms the two's-complement difference. The two low function bits pick the output from four sources: the AND term, the OR term, the adder sum, or the sign bit of the sum widened with zeros. The last of these gives set-on-less-than. Code 011 has no function and returns zero.

The adder is a carry-lookahead structure. Its block size is a parameter, and a second parameter falls back to a plain ripple chain.

Top module: `alu3_core`

## Requirements
- R1: Function code 000 returns the bitwise AND of `op_a` and `op_b`.
- R2: Function code 001 returns the bitwise OR of `op_a` and `op_b`.
- R3: Function code 010 returns `op_a + op_b` modulo 2^W, and `carry_out` is bit W of the unsigned sum.
- R4: Function code 100 returns `op_a` AND the bitwise complement of `op_b`.
- R5: Function code 101 returns `op_a` OR the bitwise complement of `op_b`.
- R6: Function code 110 returns `op_a - op_b` modulo 2^W. `carry_out` is the carry of `op_a + ~op_b + 1`, which equals 1 exactly when `op_a >= op_b` unsigned.
- R7: Function code 111 returns bit W-1 of `op_a - op_b` in bit 0, with all upper bits zero. For operands whose signed difference does not overflow, this is 1 exactly when `op_a < op_b` signed. For example, 25 against 32 returns 0x00000001.
- R8: Function code 011 returns all zeros.
- R9: For every code, `carry_out` is the adder carry-out. When function bit 2 is 0, that is the carry of `op_a + op_b`. When bit 2 is 1, it is the carry of `op_a + ~op_b + 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand; inverted when function bit 2 is set |
| func | input | 3 | Function code; bit 2 selects inversion and carry-in, bits 1:0 select the output source |
| result | output | W | Selected result |
| carry_out | output | 1 | Carry out of the shared adder |

## Verification
The bound checker evaluates every input combination the bench applies. It confirms the following properties:
- the AND and OR results match the bitwise identities;
- the sum and difference, together with the carry, match a wide arithmetic reference;
- the set-on-less-than result never has a bit set above bit 0;
- the unused code always gives zero.

Two behaviours depend on operand values that only the bench chooses. One is the signed meaning of set-on-less-than, which the bench checks only on non-overflowing pairs. The other is the carry-out under the logic codes, which is checked against the adder operation implied by bit 2.

// File: rtl/alu3_pkg.sv
// Package: shared encodings of the three-bit-coded ALU.
// Assumes bit 2 of the function code controls operand inversion and carry-in,
// and bits 1:0 select the output source.
package alu3_pkg;

    // Output source chosen by the low two function bits.
    typedef enum logic [1:0] {
        SRC_AND  = 2'b00,
        SRC_OR   = 2'b01,
        SRC_SUM  = 2'b10,
        SRC_SIGN = 2'b11
    } alu3_src_e;

    // The one function code that has no operation.
    localparam logic [2:0] FUNC_UNUSED = 3'b011;

endpackage

// File: rtl/alu3_binv.sv
// Module: conditional bitwise inverter for the second operand.
// Assumes invert is stable for the whole evaluation; purely combinational.
module alu3_binv #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         invert,
    output logic [W-1:0] dout
);

    // One XOR per bit, so inversion costs a single gate level.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[i] ^ invert;
    end

endmodule

// File: rtl/alu3_logic.sv
// Module: AND and OR terms over the first operand and the conditioned second operand.
// Assumes the inversion has already been applied by alu3_binv.
module alu3_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o
);

    // Both logic terms are formed in parallel.
    assign and_o = x & y;
    assign or_o  = x | y;

endmodule

// File: rtl/alu3_adder.sv
// Module: W-bit carry-propagate adder.
// With LOOKAHEAD = 1, blocks of BLK bits each compute a group generate and
// propagate, so the carry skips whole blocks; the last block may be shorter.
// With LOOKAHEAD = 0, the carry ripples bit by bit.
// Assumes BLK >= 1.
module alu3_adder #(
    parameter int W         = 32,
    parameter int BLK       = 4,
    parameter bit LOOKAHEAD = 1'b1
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int NBLK = (W + BLK - 1) / BLK;

    logic [W-1:0] gen;
    logic [W-1:0] prp;
    logic [W:0]   cy;

    // Per-column generate and propagate.
    assign gen   = x & y;
    assign prp   = x ^ y;
    assign cy[0] = cin;

    if (LOOKAHEAD) begin : g_cla
        logic [NBLK:0] cblk;
        assign cblk[0] = cin;

        for (genvar k = 0; k < NBLK; k++) begin : g_blk
            localparam int BASE = k * BLK;
            localparam int LEN  = (BASE + BLK > W) ? (W - BASE) : BLK;
            logic grp_g;
            logic grp_p;

            // Group generate and propagate, folded from the low column upward.
            always_comb begin
                grp_g = 1'b0;
                grp_p = 1'b1;
                for (int j = 0; j < LEN; j++) begin
                    grp_g = gen[BASE+j] | (prp[BASE+j] & grp_g);
                    grp_p = grp_p & prp[BASE+j];
                end
            end

            // The block carry skips over the block.
            assign cblk[k+1]    = grp_g | (grp_p & cblk[k]);
            assign cy[BASE+LEN] = cblk[k+1];

            // Ripple inside the block for the interior column carries.
            for (genvar j = 0; j < LEN - 1; j++) begin : g_in
                assign cy[BASE+j+1] = gen[BASE+j] | (prp[BASE+j] & cy[BASE+j]);
            end
        end
    end else begin : g_rca
        // Plain ripple chain across all columns.
        for (genvar i = 0; i < W; i++) begin : g_col
            assign cy[i+1] = gen[i] | (prp[i] & cy[i]);
        end
    end

    // The sum bit combines the column propagate with the incoming carry.
    assign sum  = prp ^ cy[W-1:0];
    assign cout = cy[W];

endmodule

// File: rtl/alu3_outmux.sv
// Module: four-way result selector with a forced-zero override.
// Assumes force_zero is asserted only for the unused function code.
module alu3_outmux
    import alu3_pkg::*;
#(
    parameter int W = 32
) (
    input  alu3_src_e    src,
    input  logic         force_zero,
    input  logic [W-1:0] and_i,
    input  logic [W-1:0] or_i,
    input  logic [W-1:0] sum_i,
    output logic [W-1:0] dout
);

    logic [W-1:0] sign_ext;

    // Widen the sum sign with zeros for set-on-less-than.
    always_comb begin
        sign_ext    = '0;
        sign_ext[0] = sum_i[W-1];
    end

    // Select the output source, or zero for the unused code.
    always_comb begin
        if (force_zero) begin
            dout = '0;
        end else begin
            unique case (src)
                SRC_AND:  dout = and_i;
                SRC_OR:   dout = or_i;
                SRC_SUM:  dout = sum_i;
                SRC_SIGN: dout = sign_ext;
                default:  dout = '0;
            endcase
        end
    end

endmodule

// File: rtl/alu3_core.sv
// Module: top of the three-bit-coded integer ALU.
// Function bit 2 inverts op_b and feeds the adder carry-in. Bits 1:0 select
// AND, OR, sum, or the zero-extended sum sign. Code 011 yields zero.
// Purely combinational, so no clock or reset is needed.
module alu3_core
    import alu3_pkg::*;
#(
    parameter int W         = 32,
    parameter int BLK       = 4,
    parameter bit LOOKAHEAD = 1'b1
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   func,
    output logic [W-1:0] result,
    output logic         carry_out
);

    logic [W-1:0] b_cond;
    logic [W-1:0] and_t;
    logic [W-1:0] or_t;
    logic [W-1:0] sum_t;
    logic         unused_code;
    alu3_src_e    src;

    // Decode the function code into its control fields.
    assign src         = alu3_src_e'(func[1:0]);
    assign unused_code = (func == FUNC_UNUSED);

    alu3_binv #(.W(W)) u_binv (
        .din    (op_b),
        .invert (func[2]),
        .dout   (b_cond)
    );

    alu3_logic #(.W(W)) u_logic (
        .x     (op_a),
        .y     (b_cond),
        .and_o (and_t),
        .or_o  (or_t)
    );

    alu3_adder #(.W(W), .BLK(BLK), .LOOKAHEAD(LOOKAHEAD)) u_add (
        .x    (op_a),
        .y    (b_cond),
        .cin  (func[2]),
        .sum  (sum_t),
        .cout (carry_out)
    );

    alu3_outmux #(.W(W)) u_mux (
        .src        (src),
        .force_zero (unused_code),
        .and_i      (and_t),
        .or_i       (or_t),
        .sum_i      (sum_t),
        .dout       (result)
    );

endmodule

// File: rtl/alu3_core_chk.sv
// Module: assertion checker for alu3_core, attached by bind.
// Each check relates the top-level ports through arithmetic identities.
module alu3_core_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [2:0]   func,
    input logic [W-1:0] result,
    input logic         carry_out
);

    logic [W:0] wide_sum;
    logic [W:0] wide_dif;

    // Wide reference arithmetic for the adder codes.
    assign wide_sum = {1'b0, op_a} + {1'b0, op_b};
    assign wide_dif = {1'b0, op_a} + {1'b0, ~op_b} + {{W{1'b0}}, 1'b1};

    // Evaluate the immediate checks whenever the ports change.
    always_comb begin
        if (func == 3'b000) begin
            // R1
            and_subset_chk: assert (((result & ~op_a) == '0) && ((result & ~op_b) == '0)
                                    && (((op_a & op_b) & ~result) == '0));
        end
        if (func == 3'b001) begin
            // R2
            or_cover_chk: assert (((result & op_a) == op_a) && ((result & op_b) == op_b)
                                  && ((result & ~(op_a | op_b)) == '0));
        end
        if (func == 3'b010) begin
            // R3
            add_wide_chk: assert ({carry_out, result} == wide_sum);
        end
        if (func == 3'b110) begin
            // R6
            sub_wide_chk: assert ({carry_out, result} == wide_dif);
        end
        if (func == 3'b111) begin
            // R7
            slt_narrow_chk: assert ((result[W-1:1] == '0) && (result[0] == wide_dif[W-1]));
        end
        if (func == 3'b011) begin
            // R8
            unused_zero_chk: assert (result == '0);
        end
        // R9
        carry_src_chk: assert (carry_out == (func[2] ? wide_dif[W] : wide_sum[W]));
    end

endmodule

bind alu3_core alu3_core_chk #(.W(W)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .func      (func),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/alu3_core_test.sv
// Bench: directed corner cases plus seeded random vectors, checked against
// reference functions written from the requirements.
module alu3_core_test;

    localparam int W = 32;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   f;
    logic [W-1:0] y;
    logic         co;
    int           checks;
    int           errors;

    alu3_core #(.W(W)) uut (
        .op_a      (a),
        .op_b      (b),
        .func      (f),
        .result    (y),
        .carry_out (co)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Expected result word for a function code.
    function automatic logic [W-1:0] exp_y(input logic [W-1:0] xa, input logic [W-1:0] xb,
                                           input logic [2:0] fc);
        logic [W-1:0] d;
        d = xa - xb;
        case (fc)
            3'b000:  return xa & xb;
            3'b001:  return xa | xb;
            3'b010:  return xa + xb;
            3'b100:  return xa & ~xb;
            3'b101:  return xa | ~xb;
            3'b110:  return d;
            3'b111:  return {{(W-1){1'b0}}, d[W-1]};
            default: return '0;
        endcase
    endfunction

    // Expected carry-out: an unsigned add, or a compare for the inverting codes.
    function automatic logic exp_c(input logic [W-1:0] xa, input logic [W-1:0] xb,
                                   input logic [2:0] fc);
        logic [W:0] s;
        s = {1'b0, xa} + {1'b0, xb};
        if (fc[2]) return (xa >= xb);
        return s[W];
    endfunction

    // True when the signed difference xa - xb overflows.
    function automatic logic sub_ovf(input logic [W-1:0] xa, input logic [W-1:0] xb);
        logic [W-1:0] d;
        d = xa - xb;
        return (xa[W-1] != xb[W-1]) && (d[W-1] != xa[W-1]);
    endfunction

    function automatic string tag_of(input logic [2:0] fc);
        case (fc)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b100:  return "R4";
            3'b101:  return "R5";
            3'b110:  return "R6";
            3'b111:  return "R7";
            default: return "R8";
        endcase
    endfunction

    // Drive on the falling edge, sample one ns after the next rising edge.
    task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic [2:0] fc);
        @(negedge clk);
        a = xa;
        b = xb;
        f = fc;
        @(posedge clk);
        #1;
        checks++;
        if (y !== exp_y(xa, xb, fc)) begin
            errors++;
            $display("FAIL %s result a=%h b=%h f=%b actual=%h expected=%h",
                     tag_of(fc), xa, xb, fc, y, exp_y(xa, xb, fc));
        end
        checks++;
        if (co !== exp_c(xa, xb, fc)) begin
            errors++;
            $display("FAIL R9 carry a=%h b=%h f=%b actual=%b expected=%b",
                     xa, xb, fc, co, exp_c(xa, xb, fc));
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        logic [2:0]   rf;
        checks = 0;
        errors = 0;
        rst_n  = 1'b0;
        a = '0;
        b = '0;
        f = 3'b000;
        repeat (3) @(posedge clk);
        #1;
        // Idle state with zero inputs: result zero, carry zero (R1, R9).
        checks++;
        if (y !== '0 || co !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle actual=%h/%b expected=0/0", y, co);
        end
        rst_n = 1'b1;

        // Directed cases for each code.
        apply(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000);      // R1
        apply(32'hA000_0001, 32'h0500_0010, 3'b001);      // R2
        apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);      // R3: wrap with carry
        apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);      // R3: no carry
        apply(32'hFFFF_0000, 32'h0F0F_0F0F, 3'b100);      // R4
        apply(32'h0000_0000, 32'hFFFF_0000, 3'b101);      // R5
        apply(32'd5, 32'd7, 3'b110);                      // R6: borrow, carry 0
        apply(32'd7, 32'd7, 3'b110);                      // R6: equal, carry 1
        apply(32'd25, 32'd32, 3'b111);                    // R7: result 1
        apply(32'd32, 32'd25, 3'b111);                    // R7: result 0
        apply(32'hFFFF_FFFF, 32'd1, 3'b111);              // R7: -1 < 1
        apply(32'hDEAD_BEEF, 32'h1234_5678, 3'b011);      // R8: zero
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);      // R8 with R9 carry 1

        // Seeded random vectors; R7 only on pairs whose difference fits.
        void'($urandom(32'd1234));
        for (int i = 0; i < 2000; i++) begin
            ra = $urandom;
            rb = $urandom;
            rf = 3'($urandom);
            if (i % 7 == 0) rb = ra;
            if (rf == 3'b111 && sub_ovf(ra, rb)) rf = 3'b110;
            apply(ra, rb, rf);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule